// File: doc/BRIEF.md
# Supply Mode Sequencer for a Gate-Driver Controller

This block is the control core of a half-bridge gate-driver controller. It steps the controller through three modes: startup, save and operating. It decides the mode from digital comparator flags on the supply and the reference, and from the low-side and high-side gate logic inputs. For each mode it drives one enable line per controlled function: the high-voltage startup generator, the reference and its current class, the reference sink path, the protection timer, overcurrent protection and the drivers.

The analog comparators are outside the block and deliver flags synchronous to `clk`. The two gate logic inputs can arrive asynchronously, so each passes through a two-flop synchronizer before edge detection. The minimum dwell in save and the low-side inactivity limit are counted in clock cycles and set by parameters. The block has no data stream, so every pin is a plain level signal with no handshake.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode is startup. In startup the startup generator is on, the reference is off (`ref_mode_o` = 0), the sink path is on, and the protection timer, overcurrent protection and drivers are off.
- R2: In startup, `vcc_on_i` high moves the block to save on the next clock edge. The startup generator output is off on entry to save.
- R3: In save the reference is in low-current class (`ref_mode_o` = 1), the sink path is off, and the protection timer, overcurrent protection and drivers are off.
- R4: In save the startup generator works with hysteresis. It switches off on the edge after `vcc_on_i` is high, switches on on the edge after `vcc_below_save_i` is high while `vcc_on_i` is low, and otherwise keeps its value.
- R5: In save, `vcc_below_refoff_i` high returns the block to startup on the next edge. This takes priority over every other transition.
- R6: The block leaves save for operating only after at least `SAVE_DWELL` cycles in save. The dwell count restarts on every entry into save.
- R7: The move from save to operating also requires `ref_good_i` high and a falling edge on the synchronized high-side input. A rising edge, or a falling edge while `ref_good_i` is low, leaves the block in save.
- R8: In operating the startup generator is off, the reference is in high-current class (`ref_mode_o` = 2), the sink path is off, and the protection timer, overcurrent protection and drivers are on.
- R9: In operating, once `IDLE_LIMIT` cycles pass with no edge on the synchronized low-side input, the block returns to save. Any low-side edge restarts that count, and so does every entry into operating.
- R10: In operating, `vcc_below_refoff_i` high returns the block to startup on the next edge, which drops the driver and protection enables.
- R11: `mode_o` encodes startup as 2'b00, save as 2'b01 and operating as 2'b10. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply at or above the turn-on threshold |
| vcc_below_save_i | input | 1 | Supply below the save-mode low threshold |
| vcc_below_refoff_i | input | 1 | Supply below the reference-off threshold |
| ref_good_i | input | 1 | Reference above 3.0 V |
| lo_gate_i | input | 1 | Low-side gate logic input (asynchronous) |
| hi_gate_i | input | 1 | High-side gate logic input (asynchronous) |
| mode_o | output | 2 | Current mode (00 startup, 01 save, 10 operating) |
| hv_gen_en_o | output | 1 | High-voltage startup generator enable |
| ref_mode_o | output | 2 | Reference class: 0 off, 1 low current, 2 high current |
| ref_sink_en_o | output | 1 | Reference sink path enable |
| prot_tmr_en_o | output | 1 | Protection timer enable |
| ocp_en_o | output | 1 | Overcurrent protection enable |
| drv_en_o | output | 1 | Driver enable |

## Verification
The first pattern is a high-side falling edge that arrives early in the save dwell. It separates a working dwell gate from one that reacts to the edge alone. A late falling edge with the reference flag low tests the reference gate, and a rising edge alone tests that the block acts only on falling edges. In operating, a low-side input held constant must drop the block to save after the limit. A low-side input that toggles at half the limit must keep the block in operating well past that limit, which shows that edges restart the inactivity count. Supply flag sequences in save test the generator hysteresis in both directions, and the reference-off flag is raised in both save and operating to check the fall back to startup.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_START = 2'b00,
    MODE_SAVE  = 2'b01,
    MODE_RUN   = 2'b10
  } mode_t;

  typedef enum logic [1:0] {
    REF_OFF  = 2'b00,
    REF_LOW  = 2'b01,
    REF_HIGH = 2'b10
  } ref_cls_t;

  typedef struct packed {
    logic     hv_gen;
    ref_cls_t ref_cls;
    logic     ref_sink;
    logic     prot_tmr;
    logic     ocp;
    logic     drv;
  } ctrl_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_edge_det.sv
module pwr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall,
  output logic any
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;

  assign rise = d & ~d_q;
  assign fall = ~d & d_q;
  assign any  = d ^ d_q;
endmodule

// File: rtl/pwr_sat_cnt.sv
module pwr_sat_cnt #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != LIM)  cnt <= cnt + 1'b1;

  assign at_limit = (cnt == LIM);
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_mode_pkg::*;
(
  input  mode_t mode,
  input  logic  hv_save,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (mode)
      MODE_START: begin
        ctrl.hv_gen   = 1'b1;
        ctrl.ref_cls  = REF_OFF;
        ctrl.ref_sink = 1'b1;
      end
      MODE_SAVE: begin
        ctrl.hv_gen  = hv_save;
        ctrl.ref_cls = REF_LOW;
      end
      MODE_RUN: begin
        ctrl.ref_cls  = REF_HIGH;
        ctrl.prot_tmr = 1'b1;
        ctrl.ocp      = 1'b1;
        ctrl.drv      = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int SAVE_DWELL  = 10,
  parameter int IDLE_LIMIT  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_below_save_i,
  input  logic       vcc_below_refoff_i,
  input  logic       ref_good_i,
  input  logic       lo_gate_i,
  input  logic       hi_gate_i,
  output logic [1:0] mode_o,
  output logic       hv_gen_en_o,
  output logic [1:0] ref_mode_o,
  output logic       ref_sink_en_o,
  output logic       prot_tmr_en_o,
  output logic       ocp_en_o,
  output logic       drv_en_o
);
  logic [1:0] gate_s;
  logic lo_rise, lo_fall, lo_edge;
  logic hi_rise, hi_fall, hi_any;
  logic dwell_done, idle_done;
  logic hv_save;
  mode_t mode_q, mode_d;
  ctrl_t ctrl;

  pwr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hi_gate_i, lo_gate_i}), .q(gate_s)
  );

  pwr_edge_det u_lo_edge (
    .clk(clk), .rst_n(rst_n), .d(gate_s[0]),
    .rise(lo_rise), .fall(lo_fall), .any(lo_edge)
  );

  pwr_edge_det u_hi_edge (
    .clk(clk), .rst_n(rst_n), .d(gate_s[1]),
    .rise(hi_rise), .fall(hi_fall), .any(hi_any)
  );

  pwr_sat_cnt #(.LIMIT(SAVE_DWELL)) u_dwell (
    .clk(clk), .rst_n(rst_n),
    .clr(mode_q != MODE_SAVE), .inc(mode_q == MODE_SAVE),
    .at_limit(dwell_done)
  );

  pwr_sat_cnt #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .clr(mode_q != MODE_RUN || lo_edge), .inc(mode_q == MODE_RUN),
    .at_limit(idle_done)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_START:
        if (vcc_on_i) mode_d = MODE_SAVE;
      MODE_SAVE:
        if (vcc_below_refoff_i)                       mode_d = MODE_START;
        else if (dwell_done && ref_good_i && hi_fall) mode_d = MODE_RUN;
      MODE_RUN:
        if (vcc_below_refoff_i)          mode_d = MODE_START;
        else if (idle_done && !lo_edge)  mode_d = MODE_SAVE;
      default: mode_d = MODE_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= MODE_START;
    else        mode_q <= mode_d;

  // startup generator hysteresis while in save
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    hv_save <= 1'b0;
    else if (mode_q != MODE_SAVE)  hv_save <= 1'b0;
    else if (vcc_on_i)             hv_save <= 1'b0;
    else if (vcc_below_save_i)     hv_save <= 1'b1;

  pwr_out_dec u_dec (.mode(mode_q), .hv_save(hv_save), .ctrl(ctrl));

  assign mode_o        = mode_q;
  assign hv_gen_en_o   = ctrl.hv_gen;
  assign ref_mode_o    = ctrl.ref_cls;
  assign ref_sink_en_o = ctrl.ref_sink;
  assign prot_tmr_en_o = ctrl.prot_tmr;
  assign ocp_en_o      = ctrl.ocp;
  assign drv_en_o      = ctrl.drv;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_on_i,
  input logic       vcc_below_save_i,
  input logic       vcc_below_refoff_i,
  input logic       ref_good_i,
  input logic       lo_gate_i,
  input logic       hi_gate_i,
  input logic [1:0] mode_o,
  input logic       hv_gen_en_o,
  input logic [1:0] ref_mode_o,
  input logic       ref_sink_en_o,
  input logic       prot_tmr_en_o,
  input logic       ocp_en_o,
  input logic       drv_en_o
);
  // R1
  startup_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b00 |-> hv_gen_en_o && ref_mode_o == 2'b00 && ref_sink_en_o
                        && !prot_tmr_en_o && !ocp_en_o && !drv_en_o);

  // R2
  startup_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b00 && vcc_on_i |=> mode_o == 2'b01 && !hv_gen_en_o);

  // R3
  save_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b01 |-> ref_mode_o == 2'b01 && !ref_sink_en_o
                        && !prot_tmr_en_o && !ocp_en_o && !drv_en_o);

  // R4
  save_hv_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b01 && !vcc_on_i && vcc_below_save_i && !vcc_below_refoff_i
    |=> mode_o != 2'b01 || hv_gen_en_o);

  // R4
  save_hv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b01 && vcc_on_i && !vcc_below_refoff_i |=> !hv_gen_en_o);

  // R5
  save_refoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b01 && vcc_below_refoff_i |=> mode_o == 2'b00);

  // R7
  run_entry_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b01 && !ref_good_i |=> mode_o != 2'b10);

  // R8
  run_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b10 |-> !hv_gen_en_o && ref_mode_o == 2'b10 && !ref_sink_en_o
                        && prot_tmr_en_o && ocp_en_o && drv_en_o);

  // R10
  run_refoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b10 && vcc_below_refoff_i |=> mode_o == 2'b00 && !drv_en_o);

  // R11
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  // R6: startup never jumps straight to operating
  no_skip_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b00 |=> mode_o != 2'b10);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_chk (.*);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on = 0, vcc_save = 0, vcc_refoff = 0, ref_good = 0, lo = 0, hi = 0;
  logic [1:0] mode, ref_mode;
  logic hv, sink, prot, ocp, drv;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [8:0] exp;
  } item_t;
  item_t sb_q[$];
  event sb_ev;

  always #2 clk = ~clk;

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n),
    .vcc_on_i(vcc_on), .vcc_below_save_i(vcc_save),
    .vcc_below_refoff_i(vcc_refoff), .ref_good_i(ref_good),
    .lo_gate_i(lo), .hi_gate_i(hi),
    .mode_o(mode), .hv_gen_en_o(hv), .ref_mode_o(ref_mode),
    .ref_sink_en_o(sink), .prot_tmr_en_o(prot), .ocp_en_o(ocp), .drv_en_o(drv)
  );

  // expected vector: {mode, hv, ref, sink, prot, ocp, drv}
  localparam logic [8:0] ST_START   = {2'b00, 1'b1, 2'b00, 1'b1, 3'b000};
  localparam logic [8:0] ST_SAVE_HV0 = {2'b01, 1'b0, 2'b01, 1'b0, 3'b000};
  localparam logic [8:0] ST_SAVE_HV1 = {2'b01, 1'b1, 2'b01, 1'b0, 3'b000};
  localparam logic [8:0] ST_RUN     = {2'b10, 1'b0, 2'b10, 1'b0, 3'b111};

  task automatic expect_now(input string tag, input logic [8:0] exp);
    item_t it;
    it.tag = tag;
    it.exp = exp;
    sb_q.push_back(it);
    -> sb_ev;
    #0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares popped items against the ports
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [8:0] act;
        it = sb_q.pop_front();
        act = {mode, hv, ref_mode, sink, prot, ocp, drv};
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic hi_fall_pulse;
    hi = 1'b1; cyc(4);
    hi = 1'b0; cyc(5);
  endtask

  initial begin
    cyc(3);
    expect_now("R1 in reset", ST_START);
    rst_n = 1'b1;
    cyc(3);
    expect_now("R1 after reset", ST_START);

    vcc_on = 1'b1; cyc(1);
    expect_now("R2 R3 R11 save entry", ST_SAVE_HV0);

    vcc_on = 1'b0; vcc_save = 1'b1; cyc(1);
    expect_now("R4 generator on", ST_SAVE_HV1);
    vcc_save = 1'b0; cyc(2);
    expect_now("R4 hysteresis hold", ST_SAVE_HV1);
    vcc_on = 1'b1; cyc(1);
    expect_now("R4 generator off", ST_SAVE_HV0);

    vcc_on = 1'b0; vcc_refoff = 1'b1; cyc(1);
    expect_now("R5 save to startup", ST_START);
    vcc_refoff = 1'b0; cyc(2);

    // fresh save entry, early falling edge must be ignored
    ref_good = 1'b1;
    vcc_on = 1'b1; cyc(1); vcc_on = 1'b0;
    hi = 1'b1; cyc(3); hi = 1'b0; cyc(4);
    expect_now("R6 early fall ignored", ST_SAVE_HV0);
    cyc(10);
    ref_good = 1'b0;
    hi_fall_pulse();
    expect_now("R7 fall with ref low ignored", ST_SAVE_HV0);
    ref_good = 1'b1;
    hi = 1'b1; cyc(5);
    expect_now("R7 rising edge ignored", ST_SAVE_HV0);
    hi = 1'b0; cyc(5);
    expect_now("R6 R7 R8 enter operating", ST_RUN);

    // inactivity timeout
    cyc(85);
    expect_now("R9 before limit", ST_RUN);
    cyc(25);
    expect_now("R9 timeout to save", ST_SAVE_HV0);

    hi_fall_pulse();
    expect_now("R6 re-enter operating", ST_RUN);
    for (int k = 0; k < 6; k++) begin
      lo = ~lo; cyc(50);
    end
    expect_now("R9 edges hold operating", ST_RUN);
    cyc(110);
    expect_now("R9 timeout after edges", ST_SAVE_HV0);

    hi_fall_pulse();
    expect_now("R8 operating again", ST_RUN);
    vcc_refoff = 1'b1; cyc(1);
    expect_now("R10 operating to startup", ST_START);
    vcc_refoff = 1'b0; cyc(2);
    expect_now("R1 startup holds", ST_START);

    cyc(1);
    #0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule